// File: doc/BRIEF.md
# Watch-Crystal Prescaler and Wake Timer

This block is the slow timebase of a small low-power controller. It runs on the oscillator clock and divides it into a prescaler tick. With the watch crystal selected, the tick is 1/32 of the clock (1024 Hz from 32.768 kHz). With the internal clock selected, the tick runs at the full clock rate. The ticks feed two consumers.

A programmable interval counter turns every N ticks into a one-cycle timer interrupt. A fixed 64-tick overflow divider produces a 16 Hz pulse in crystal mode. That pulse can wake the core from internal halt. It cannot end external halt.

Internal-halt support is a build-time choice, and it is legal only with the crystal source. If a configuration asks for internal halt without the crystal, the block treats it as having no wake source.

Top module: `wake_timebase`

## Requirements
- R1: While `rst_n` is low at a clock edge, `timer_irq` and `wake_req` are 0 after that edge.
- R2: With `src_xtal`=1, a reload write of N (1..1023) restarts the prescaler. `timer_irq` then goes high exactly N*32 clock edges after the write edge, and again every N*32 edges after that.
- R3: With `src_xtal`=0, the prescaler ticks every clock. A reload write of N gives a `timer_irq` period of N clock edges.
- R4: A reload value of 0 selects a full count of 1024 ticks: 32768 edges in crystal mode and 1024 edges in internal mode.
- R5: In crystal mode `timer_irq` is a one-cycle pulse. It is low on the edge after it was high.
- R6: With `src_xtal`=1, `ihalt_en`=1, `in_ihalt`=1 and `in_xhalt`=0 held from reset, `wake_req` first goes high 2048 edges after reset is released. That is the 64th prescaler tick, the 16 Hz overflow.
- R7: While `in_xhalt`=1, the overflow never raises `wake_req`.
- R8: With `ihalt_en`=1 and `src_xtal`=0 (an illegal configuration), `wake_req` never rises.
- R9: A raised `wake_req` stays high while `in_ihalt`=1. It is 0 after the first edge at which `in_ihalt` is 0.
- R10: A synchronous reset clears a pending `wake_req` at the next edge.
- R11: While `in_ihalt`=0, the overflow never raises `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (crystal or internal) |
| rst_n | input | 1 | Synchronous active-low reset |
| src_xtal | input | 1 | Clock source option: 1 = watch crystal (divide by 32), 0 = internal clock (divide by 1) |
| ihalt_en | input | 1 | Internal-halt support option; legal only with `src_xtal`=1 |
| reload_wr | input | 1 | Write strobe for the interval reload value; restarts prescaler and counter |
| reload_val | input | 10 | Interval length in ticks; 0 means 1024 |
| in_ihalt | input | 1 | Core is in internal halt |
| in_xhalt | input | 1 | Core is in external halt |
| timer_irq | output | 1 | Interval interrupt pulse |
| wake_req | output | 1 | Pending wake request from internal halt |

## Verification
The assertions take the two option inputs, `src_xtal` and `ihalt_en`, as constant outside reset. They also take `in_ihalt` and `in_xhalt` as levels that change only at the halt entries and exits the bench chooses. The bench sets both options, and every halt level it needs, only while reset is asserted. The one exception is the deliberate drop of `in_ihalt` that tests the release. Reload writes happen only outside halt scenarios. All inputs change on the falling clock edge.

// File: rtl/wtb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the reload-length helper for the timebase.
// Assumes interval widths of at most 16 bits.
package wtb_pkg;
    localparam int XTAL_DIV_DEF  = 32;   // crystal clock to tick ratio
    localparam int INT_DIV_DEF   = 1;    // internal clock to tick ratio
    localparam int OVF_TICKS_DEF = 64;   // ticks per overflow pulse
    localparam int IVAL_W_DEF    = 10;   // interval reload width

    // Convert a reload field into a tick count; zero means the full range.
    function automatic logic [16:0] ival_len(input logic [15:0] r, input int w);
        logic [16:0] full;
        full = 17'(1) << w;
        return (r == 16'd0) ? full : {1'b0, r};
    endfunction
endpackage

// File: rtl/wtb_prescaler.sv
`timescale 1ns/1ps
// Module: prescaler. Divides the oscillator clock into a single-cycle tick
// enable, by XDIV in crystal mode and by IDIV in internal mode.
// Assumes use_xtal is static outside reset; restart realigns the phase.
module wtb_prescaler #(
    parameter int XDIV = 32,
    parameter int IDIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic use_xtal,
    input  logic restart,
    output logic tick
);
    localparam int MAXDIV = (XDIV > IDIV) ? XDIV : IDIV;
    localparam int PW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] limit;

    generate
        if (IDIV == 1) begin : g_int_pass
            // Internal source runs undivided: tick every clock.
            always_comb limit = use_xtal ? PW'(XDIV - 1) : '0;
        end else begin : g_int_div
            // Both sources divided: pick the terminal phase per source.
            always_comb limit = use_xtal ? PW'(XDIV - 1) : PW'(IDIV - 1);
        end
    endgenerate

    assign tick = (phase_q == limit);

    // Phase counter: wraps at the terminal phase, cleared by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/wtb_interval.sv
`timescale 1ns/1ps
// Module: interval timer. Counts prescaler ticks down from a reload value
// and emits a registered one-cycle interrupt when the count is used up.
// Assumes wr and tick are single-cycle enables; wr wins over tick.
module wtb_interval #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [CW-1:0] wr_val,
    output logic          irq
);
    import wtb_pkg::*;

    localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

    logic [CW-1:0] reload_q;
    logic [CW:0]   remain_q;
    logic          irq_q;
    logic [CW:0]   wr_len;
    logic [CW:0]   rel_len;

    // Tick counts for the new write and for the stored reload.
    always_comb begin
        wr_len  = (CW+1)'(ival_len(16'(wr_val), CW));
        rel_len = (CW+1)'(ival_len(16'(reload_q), CW));
    end

    // Reload register, remaining-tick counter and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            remain_q <= FULL;
            irq_q    <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (wr) begin
                reload_q <= wr_val;
                remain_q <= wr_len;
            end else if (tick) begin
                if (remain_q == (CW+1)'(1)) begin
                    irq_q    <= 1'b1;
                    remain_q <= rel_len;
                end else begin
                    remain_q <= remain_q - 1'b1;
                end
            end
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/wtb_wake.sv
`timescale 1ns/1ps
// Module: overflow divider and wake logic. Counts OVF ticks per overflow
// and latches a wake request on overflow during internal halt only.
// Assumes the option inputs are static; an illegal option pair disables wake.
module wtb_wake #(
    parameter int OVF = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic use_xtal,
    input  logic ihalt_en,
    input  logic in_ihalt,
    input  logic in_xhalt,
    output logic wake
);
    localparam int OW = (OVF > 1) ? $clog2(OVF) : 1;

    logic [OW-1:0] ovf_q;
    logic          ovf_hit;
    logic          legal;
    logic          pend_q;

    assign ovf_hit = tick && (ovf_q == OW'(OVF - 1));
    assign legal   = ihalt_en && use_xtal;

    // Overflow divider: counts ticks and wraps after OVF of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else if (ovf_hit) begin
            ovf_q <= '0;
        end else if (tick) begin
            ovf_q <= ovf_q + 1'b1;
        end
    end

    // Wake latch: set by overflow in internal halt, dropped when halt ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!in_ihalt) begin
            pend_q <= 1'b0;
        end else if (ovf_hit && legal && !in_xhalt) begin
            pend_q <= 1'b1;
        end
    end

    assign wake = pend_q;
endmodule

// File: rtl/wake_timebase.sv
`timescale 1ns/1ps
// Module: top of the watch-crystal timebase. Joins prescaler, interval
// timer and overflow wake logic on one oscillator clock.
// Assumes option inputs are tied or changed only under reset.
module wake_timebase #(
    parameter int XTAL_DIV  = wtb_pkg::XTAL_DIV_DEF,
    parameter int INT_DIV   = wtb_pkg::INT_DIV_DEF,
    parameter int OVF_TICKS = wtb_pkg::OVF_TICKS_DEF,
    parameter int IVAL_W    = wtb_pkg::IVAL_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_xtal,
    input  logic              ihalt_en,
    input  logic              reload_wr,
    input  logic [IVAL_W-1:0] reload_val,
    input  logic              in_ihalt,
    input  logic              in_xhalt,
    output logic              timer_irq,
    output logic              wake_req
);
    logic tick;

    wtb_prescaler #(.XDIV(XTAL_DIV), .IDIV(INT_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .use_xtal (src_xtal),
        .restart  (reload_wr),
        .tick     (tick)
    );

    wtb_interval #(.CW(IVAL_W)) u_ival (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .wr     (reload_wr),
        .wr_val (reload_val),
        .irq    (timer_irq)
    );

    wtb_wake #(.OVF(OVF_TICKS)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .use_xtal (src_xtal),
        .ihalt_en (ihalt_en),
        .in_ihalt (in_ihalt),
        .in_xhalt (in_xhalt),
        .wake     (wake_req)
    );
endmodule

// File: rtl/wtb_checker.sv
`timescale 1ns/1ps
// Module: property checker for the timebase, bound onto the top module.
// Assumes options are static outside reset.
module wtb_checker (
    input logic clk,
    input logic rst_n,
    input logic src_xtal,
    input logic ihalt_en,
    input logic in_ihalt,
    input logic in_xhalt,
    input logic timer_irq,
    input logic wake_req
);
    // R5: crystal-mode interrupt lasts a single cycle.
    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_xtal && timer_irq) |=> !timer_irq);

    // R7: a new wake request never follows a cycle spent in external halt.
    a_r7_no_xhalt_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(!in_xhalt));

    // R8: a wake request needs the legal option pair.
    a_r8_legal_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(ihalt_en && src_xtal));

    // R9: leaving internal halt drops the request.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ihalt |=> !wake_req);

    // R11: a wake request is only raised from internal halt.
    a_r11_ihalt_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> $past(in_ihalt));
endmodule

bind wake_timebase wtb_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_xtal  (src_xtal),
    .ihalt_en  (ihalt_en),
    .in_ihalt  (in_ihalt),
    .in_xhalt  (in_xhalt),
    .timer_irq (timer_irq),
    .wake_req  (wake_req)
);

// File: tb/tb_wake_timebase.sv
`timescale 1ns/1ps
module tb_wake_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_xtal = 1'b1;
    logic       ihalt_en = 1'b0;
    logic       reload_wr = 1'b0;
    logic [9:0] reload_val = '0;
    logic       in_ihalt = 1'b0;
    logic       in_xhalt = 1'b0;
    logic       timer_irq;
    logic       wake_req;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    wake_timebase dut (
        .clk(clk), .rst_n(rst_n), .src_xtal(src_xtal), .ihalt_en(ihalt_en),
        .reload_wr(reload_wr), .reload_val(reload_val),
        .in_ihalt(in_ihalt), .in_xhalt(in_xhalt),
        .timer_irq(timer_irq), .wake_req(wake_req)
    );

    // {xtal, reload[9:0], expected period in edges[16:0]}
    localparam int NV = 6;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 10'd1, 17'd32},
        {1'b1, 10'd5, 17'd160},
        {1'b1, 10'd0, 17'd32768},
        {1'b0, 10'd7, 17'd7},
        {1'b0, 10'd0, 17'd1024},
        {1'b0, 10'd1, 17'd1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit x, input bit ie, input bit ih, input bit xh);
        @(negedge clk);
        rst_n = 1'b0; src_xtal = x; ihalt_en = ie; in_ihalt = ih; in_xhalt = xh;
        reload_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(timer_irq == 1'b0 && wake_req == 1'b0, "R1 reset outputs",
            {timer_irq, wake_req}, 0);
        rst_n = 1'b1;
    endtask

    // Counts edges until wake_req is seen high; 0 if not within the limit.
    task automatic wait_wake(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); #1;
            if (wake_req) begin n = i; break; end
        end
    endtask

    // Counts edges until timer_irq is seen high.
    task automatic wait_irq(input int lim, output int n);
        n = 0;
        for (int i = 1; i <= lim; i++) begin
            @(posedge clk); #1;
            if (timer_irq) begin n = i; break; end
        end
    endtask

    initial begin
        #(4 * 195000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        // Vector table: R2, R3, R4 periods and R5 pulse width.
        for (int v = 0; v < NV; v++) begin
            logic       x;
            logic [9:0] r;
            int         p;
            x = VEC[v][27];
            r = VEC[v][26:17];
            p = int'(VEC[v][16:0]);
            do_reset(x, 1'b0, 1'b0, 1'b0);
            @(negedge clk);
            reload_wr = 1'b1; reload_val = r;
            @(posedge clk); #1;
            reload_wr = 1'b0;
            wait_irq(p + 10, n);
            chk(n == p, (r == 0) ? "R4 first period" : (x ? "R2 first period" : "R3 first period"), n, p);
            wait_irq(p + 10, n);
            chk(n == p, (r == 0) ? "R4 second period" : (x ? "R2 second period" : "R3 second period"), n, p);
            if (x) begin
                @(posedge clk); #1;
                chk(timer_irq == 1'b0, "R5 single-cycle pulse", timer_irq, 0);
            end
        end

        // R6: overflow wakes from internal halt at edge 2048.
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        wait_wake(2100, n);
        chk(n == 2048, "R6 wake timing", n, 2048);
        // R9: request held during halt, then released.
        repeat (5) @(posedge clk);
        #1 chk(wake_req == 1'b1, "R9 wake held", wake_req, 1);
        @(negedge clk); in_ihalt = 1'b0;
        @(posedge clk); #1;
        chk(wake_req == 1'b0, "R9 wake released", wake_req, 0);

        // R10: reset clears a pending request.
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        wait_wake(2100, n);
        chk(n == 2048, "R10 wake before reset", n, 2048);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk(wake_req == 1'b0, "R10 reset clears wake", wake_req, 0);

        // R7: external halt is not ended by the overflow.
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        wait_wake(2200, n);
        chk(n == 0, "R7 no wake in external halt", n, 0);

        // R8: illegal option pair never wakes.
        do_reset(1'b0, 1'b1, 1'b1, 1'b0);
        wait_wake(2200, n);
        chk(n == 0, "R8 no wake illegal config", n, 0);

        // R11: not halted, no wake.
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        wait_wake(2200, n);
        chk(n == 0, "R11 no wake outside halt", n, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule